// File: doc/BRIEF.md
# PHY Power Sequencer

This block drives the two analog control lines of a storage-interface PHY: an active-low power-down line and a DLL enable. It turns single-cycle power-on and power-off requests into the fixed ordered sequence that the analog circuits need. Every sequence first pulls both control lines low. A power-off stops there. A power-on then holds the power-down line low so the calibration logic can initialize, raises it, and waits. It samples the calibration-complete flag once, enables the DLL only if that flag is set, waits again, and samples the DLL-locked flag once.

All waits are given in nanoseconds and converted to clock cycles from the clock frequency parameter, with rounding up. One down-counter times every wait. Completion is reported with a one-cycle done pulse, a busy level and a 2-bit error code. The control lines and the error code keep their values until the next accepted request.

Top module: `phy_pwr_seq`

## Requirements
- R1: While reset is held, pd_n_o, dll_en_o, busy_o and done_o are 0 and err_o is 0.
- R2: A power-off request accepted while idle drives pd_n_o and dll_en_o to 0 at the next clock edge. At that same edge it pulses done_o with err_o = 0 (OK), and busy_o stays 0.
- R3: A power-on request accepted while idle drives pd_n_o and dll_en_o to 0 and sets busy_o at the next edge, call it edge 0. pd_n_o rises at edge SETTLE (the settle time in cycles).
- R4: cal_ok_i is sampled only at edge SETTLE+CAL. Its value at any other cycle of the sequence has no effect.
- R5: If cal_ok_i is 0 at its sample edge, the sequence ends at that edge: err_o = 1 (calibration timeout), done_o pulses, busy_o falls, pd_n_o stays 1 and dll_en_o stays 0.
- R6: dll_en_o rises only at the edge where cal_ok_i is sampled as 1, and it is never 1 while pd_n_o is 0.
- R7: dll_lock_i is sampled only at edge SETTLE+CAL+LOCK. The sequence then ends with err_o = 0 if the flag is 1, or err_o = 2 (DLL timeout) if it is 0.
- R8: done_o is high for exactly one cycle, at the edge where busy_o falls.
- R9: Power-on and power-off requests that arrive while busy_o is 1 are ignored.
- R10: While idle and without a request, pd_n_o, dll_en_o and err_o keep their values whatever the flag inputs do.
- R11: If req_on_i and req_off_i are both high while idle, the power-off sequence runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_on_i | input | 1 | Power-on request |
| req_off_i | input | 1 | Power-off request |
| cal_ok_i | input | 1 | Calibration complete flag from the PHY |
| dll_lock_i | input | 1 | DLL locked flag from the PHY |
| pd_n_o | output | 1 | Active-low power-down to the PHY |
| dll_en_o | output | 1 | DLL enable to the PHY |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 2 | Result: 0 OK, 1 calibration timeout, 2 DLL timeout |

## Verification
The hardest case to reach from the ports is a flag that is valid only at its single sample edge. Proving that the controller does not poll needs the opposite value on the flag in every other cycle of the wait. The bench drives each flag inverted throughout its wait and gives it the wanted value only for the sample edge. It sweeps both flag outcomes against requests of each kind injected while busy. A small clock-frequency setting keeps every wait a few cycles long, so each edge can be compared with counts computed in the bench.

// File: rtl/pps_pkg.sv
// Shared types for the PHY power sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CALW   = 2'd2,
        ST_LOCKW  = 2'd3
    } pps_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_CAL_TMO = 2'd1,
        RES_DLL_TMO = 2'd2
    } pps_res_e;

    // Converts a time in ns to whole clock cycles, rounding up, minimum 1.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/pps_timer.sv
// Single down-counter shared by all waits of the sequencer.
// Assumes: the owner only decrements while the count is non-zero.
module pps_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new wait or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load)   cnt_q <= load_val;
        else if (dec)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0)); // R3

endmodule

// File: rtl/pps_fsm.sv
// Sequence controller: orders the control lines and samples each PHY flag
// once at the end of its wait.
// Assumes: the timer's zero flag reflects the value last loaded.
module pps_fsm
    import pps_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int SETTLE_CYC = 750,
    parameter int CAL_CYC    = 1250,
    parameter int LOCK_CYC   = 2750
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_on,
    input  logic             req_off,
    input  logic             cal_ok,
    input  logic             dll_lock,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tmr_dec,
    output logic             pd_n,
    output logic             dll_en,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err
);

    pps_state_e st_q, st_d;
    logic       go_off, go_on;

    assign go_off = (st_q == ST_IDLE) && req_off;
    assign go_on  = (st_q == ST_IDLE) && req_on && !req_off;

    // Next state and timer loads.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st_q)
            ST_IDLE: if (go_on) begin
                st_d     = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(SETTLE_CYC - 1);
            end
            ST_SETTLE: if (tmr_zero) begin
                st_d     = ST_CALW;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(CAL_CYC - 1);
            end
            ST_CALW: if (tmr_zero) begin
                if (cal_ok) begin
                    st_d     = ST_LOCKW;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LOCK_CYC - 1);
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_LOCKW: if (tmr_zero) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign tmr_dec = !tmr_load && (st_q != ST_IDLE) && !tmr_zero;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Registered control lines and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_n   <= 1'b0;
            dll_en <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
            err    <= RES_OK;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (go_off || go_on) begin
                        pd_n   <= 1'b0;
                        dll_en <= 1'b0;
                        err    <= RES_OK;
                    end
                    if (go_off) done <= 1'b1;
                    if (go_on)  busy <= 1'b1;
                end
                ST_SETTLE: if (tmr_zero) pd_n <= 1'b1;
                ST_CALW: if (tmr_zero) begin
                    if (cal_ok) begin
                        dll_en <= 1'b1;
                    end else begin
                        err  <= RES_CAL_TMO;
                        done <= 1'b1;
                        busy <= 1'b0;
                    end
                end
                ST_LOCKW: if (tmr_zero) begin
                    err  <= dll_lock ? RES_OK : RES_DLL_TMO;
                    done <= 1'b1;
                    busy <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    AST_DLL_NEEDS_PDB: assert property (@(posedge clk) disable iff (!rst_n)
        dll_en |-> pd_n); // R6
    AST_DLL_RISE_ON_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en) |-> $past(cal_ok)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_BUSY_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (err == RES_OK)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_on && !req_off) |=> $stable({pd_n, dll_en, err})); // R10

endmodule

// File: rtl/phy_pwr_seq.sv
// Top of the PHY power sequencer: converts wait times to cycles and joins
// the controller to its shared timer.
// Assumes: requests and PHY flags are synchronous to clk.
module phy_pwr_seq
    import pps_pkg::*;
#(
    parameter int CLK_MHZ   = 250,
    parameter int SETTLE_NS = 3000,
    parameter int CAL_NS    = 5000,
    parameter int LOCK_NS   = 11000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_on_i,
    input  logic       req_off_i,
    input  logic       cal_ok_i,
    input  logic       dll_lock_i,
    output logic       pd_n_o,
    output logic       dll_en_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] err_o
);

    localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_MHZ);
    localparam int CAL_CYC    = ns_to_cyc(CAL_NS, CLK_MHZ);
    localparam int LOCK_CYC   = ns_to_cyc(LOCK_NS, CLK_MHZ);
    localparam int MAX_CYC    = (SETTLE_CYC > CAL_CYC)
                              ? ((SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC)
                              : ((CAL_CYC > LOCK_CYC) ? CAL_CYC : LOCK_CYC);
    localparam int CNT_W      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic             tmr_load, tmr_dec, tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    pps_fsm #(
        .CNT_W      (CNT_W),
        .SETTLE_CYC (SETTLE_CYC),
        .CAL_CYC    (CAL_CYC),
        .LOCK_CYC   (LOCK_CYC)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_on   (req_on_i),
        .req_off  (req_off_i),
        .cal_ok   (cal_ok_i),
        .dll_lock (dll_lock_i),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .tmr_dec  (tmr_dec),
        .pd_n     (pd_n_o),
        .dll_en   (dll_en_o),
        .busy     (busy_o),
        .done     (done_o),
        .err      (err_o)
    );

    pps_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

endmodule

// File: tb/test_phy_pwr_seq.sv
`timescale 1ns/1ps
module test_phy_pwr_seq;

    // At 1 MHz the waits come out to 3, 4 and 5 cycles.
    localparam int S = 3;
    localparam int C = 4;
    localparam int L = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_on, req_off, cal_ok, dll_lock;
    logic       pd_n, dll_en, busy, done;
    logic [1:0] err;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    phy_pwr_seq #(
        .CLK_MHZ   (1),
        .SETTLE_NS (3000),
        .CAL_NS    (4000),
        .LOCK_NS   (5000)
    ) i_phy_pwr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_on_i   (req_on),
        .req_off_i  (req_off),
        .cal_ok_i   (cal_ok),
        .dll_lock_i (dll_lock),
        .pd_n_o     (pd_n),
        .dll_en_o   (dll_en),
        .busy_o     (busy),
        .done_o     (done),
        .err_o      (err)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One power-on sequence; kind 1..3 injects on, off or both while busy.
    task automatic run_on(input bit cv, input bit lv, input int kind);
        int e;
        int code;
        e    = cv ? (S + C + L) : (S + C);
        code = !cv ? 1 : (!lv ? 2 : 0);
        for (int j = 0; j <= e + 1; j++) begin
            req_on   = (j == 0) || (kind != 0 && j == kind + 1 && kind != 2);
            req_off  = (kind >= 2 && j == kind + 1);
            cal_ok   = (j == S + C)     ? cv : !cv;
            dll_lock = (j == S + C + L) ? lv : !lv;
            step();
            req_on  = 1'b0;
            req_off = 1'b0;
            chk("R3", "pd_n", pd_n, (j >= S) ? 1 : 0);
            chk("R4 R6", "dll_en", dll_en, (cv && j >= S + C) ? 1 : 0);
            chk(kind != 0 ? "R9" : "R3", "busy", busy, (j < e) ? 1 : 0);
            chk("R8", "done", done, (j == e) ? 1 : 0);
            chk(cv ? "R7" : "R5", "err", err, (j < e) ? 0 : code);
        end
        // Idle hold with flags toggling.
        for (int h = 0; h < 3; h++) begin
            cal_ok   = h[0];
            dll_lock = !h[0];
            step();
            chk("R10", "pd_n", pd_n, 1);
            chk("R10", "dll_en", dll_en, cv ? 1 : 0);
            chk("R10", "err", err, code);
            chk("R10", "done", done, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_on = 1'b0; req_off = 1'b0;
        cal_ok = 1'b1; dll_lock = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pd_n", pd_n, 0);
        chk("R1", "dll_en", dll_en, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "err", err, 0);
        rst_n = 1'b1;
        step();

        // Power-off from idle.
        req_off = 1'b1;
        step();
        req_off = 1'b0;
        chk("R2", "pd_n", pd_n, 0);
        chk("R2", "dll_en", dll_en, 0);
        chk("R2", "done", done, 1);
        chk("R2", "busy", busy, 0);
        chk("R2", "err", err, 0);
        step();
        chk("R8", "done", done, 0);

        for (int k = 0; k < 4; k++)
            for (int c = 0; c < 2; c++)
                for (int l = 0; l < 2; l++)
                    run_on(c[0], l[0], k);

        // Last run left both lines high with OK; both requests at once.
        req_on = 1'b1; req_off = 1'b1;
        step();
        req_on = 1'b0; req_off = 1'b0;
        chk("R11", "pd_n", pd_n, 0);
        chk("R11", "dll_en", dll_en, 0);
        chk("R11", "done", done, 1);
        chk("R11", "busy", busy, 0);
        chk("R11", "err", err, 0);
        step();
        chk("R11", "busy", busy, 0);

        // Power-off after a DLL timeout clears the error.
        run_on(1'b1, 1'b0, 0);
        req_off = 1'b1;
        step();
        req_off = 1'b0;
        chk("R2", "err", err, 0);
        chk("R2", "pd_n", pd_n, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule